// File: doc/BRIEF.md
# Day-of-week clock alarm matcher

This block keeps a four-byte alarm setting: seconds, minutes, hours and day of week, each in BCD. Once per second it compares the setting with the running clock. When all four fields agree, it sets a sticky alarm flag. The flag stays high until the host touches the clock or the alarm setting. A separate single-cycle access event, raised by the surrounding host interface on any such read or write, clears it.

The clock counter sits outside this block, and so does the serial host interface. The host writes and reads the alarm bytes through a small byte-addressed port. Address 0 is seconds, 1 is minutes, 2 is hours and 3 is day of week. The hours byte carries the 12/24-hour select in bit 6 and AM/PM in bit 5 (in 12-hour mode). These bits are stored and compared exactly as written, with no translation, so the host must keep them consistent with the clock's own mode. The day of week runs from 1 to 7, with 1 meaning Sunday.

Top module: `clk_alarm_match`

## Requirements
- R1: After reset, alarm_o is low and the four alarm bytes read 8'h00, 8'h00, 8'h52, 8'h01 at addresses 0..3. This is 12:00 AM, 12-hour mode, Sunday.
- R2: A write with wr_en_i high stores wr_data_i at address addr_i on the clock edge. From the next cycle, rd_data_o shows the stored byte whenever addr_i selects it. Without a write, the stored bytes keep their values.
- R3: Only certain bits are stored on writes: mask 8'h7F at addresses 0, 1 and 2, and mask 8'h07 at address 3. Bits outside the mask are ignored on writes and always read as zero.
- R4: The hours byte is compared bit for bit, including bit 6 (12/24 select) and bit 5. A clock in 12-hour mode never matches an alarm in 24-hour mode with the same digits.
- R5: alarm_o is high in the cycle after a tick_i cycle in which all four masked clock bytes equal the alarm bytes and access_i is low.
- R6: A match with tick_i low does not set alarm_o.
- R7: A mismatch in any single field (seconds, minutes, hours or day) keeps alarm_o low after a tick.
- R8: Once set, alarm_o stays high across later ticks, whether or not the clock matches, until access_i is seen.
- R9: access_i clears alarm_o on the next edge and takes priority over a tick with a match in the same cycle. A later tick sets the flag again if the match still holds.
- R10: Clock input bits outside the field masks of R3 do not take part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| cur_sec_i | input | 8 | Current clock seconds, BCD |
| cur_min_i | input | 8 | Current clock minutes, BCD |
| cur_hour_i | input | 8 | Current clock hours, BCD with mode bits |
| cur_day_i | input | 8 | Current day of week, 1..7 |
| addr_i | input | 2 | Alarm byte select for read and write |
| wr_en_i | input | 1 | Alarm byte write strobe |
| wr_data_i | input | 8 | Alarm byte write data |
| access_i | input | 1 | Host read or write of clock or alarm register happened |
| rd_data_o | output | 8 | Alarm byte selected by addr_i |
| alarm_o | output | 1 | Sticky alarm flag |

## Verification
The comparison is tried with five kinds of clock pattern. An exact match must set the flag. Four patterns each break one field by one count, which shows that every field takes part in the decision. A pattern with all non-stored bits forced high shows that those bits are masked out. Patterns that differ only in bits 6 or 5 of the hours byte show that the mode bits are compared and not translated. Directed sequences then separate an untimed match from a ticked one, a sticky flag from a level-following one, and clear priority from set priority when both arrive together.

// File: rtl/clk_alarm_pkg.sv
package clk_alarm_pkg;
  localparam int unsigned NUM_FIELDS = 4;
  localparam int unsigned BYTE_W     = 8;

  // stored-bit mask per field
  function automatic logic [BYTE_W-1:0] field_mask(input int unsigned idx);
    case (idx)
      3:       field_mask = 8'h07;
      default: field_mask = 8'h7F;
    endcase
  endfunction

  // 12:00 AM, 12-hour mode, Sunday
  function automatic logic [BYTE_W-1:0] field_rst(input int unsigned idx);
    case (idx)
      2:       field_rst = 8'h52;
      3:       field_rst = 8'h01;
      default: field_rst = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import clk_alarm_pkg::*;
#(
  parameter int unsigned NF = NUM_FIELDS,
  parameter int unsigned BW = BYTE_W,
  localparam int unsigned AW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [AW-1:0]          addr_i,
  input  logic                   wr_en_i,
  input  logic [BW-1:0]          wr_data_i,
  output logic [BW-1:0]          rd_data_o,
  output logic [NF-1:0][BW-1:0]  alarm_q_o
);
  logic [NF-1:0][BW-1:0] alarm_q;

  for (genvar g = 0; g < NF; g++) begin : g_field
    localparam logic [BW-1:0] MASK = BW'(field_mask(g));
    localparam logic [BW-1:0] RSTV = BW'(field_rst(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   alarm_q[g] <= RSTV;
      else if (wr_en_i && (addr_i == AW'(g)))        alarm_q[g] <= wr_data_i & MASK;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NF; i++)
      if (addr_i == AW'(i)) rd_data_o = alarm_q[i];
  end

  assign alarm_q_o = alarm_q;

  // R2: no write, no change
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(alarm_q));
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import clk_alarm_pkg::*;
#(
  parameter int unsigned NF = NUM_FIELDS,
  parameter int unsigned BW = BYTE_W
) (
  input  logic [NF-1:0][BW-1:0] clock_i,
  input  logic [NF-1:0][BW-1:0] alarm_i,
  output logic                  match_o
);
  logic [NF-1:0] eq;

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    localparam logic [BW-1:0] MASK = BW'(field_mask(g));
    assign eq[g] = ((clock_i[g] & MASK) == alarm_i[g]);
  end

  assign match_o = &eq;
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic match_i,
  input  logic access_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_o <= 1'b0;
    else if (access_i)           flag_o <= 1'b0;   // clear wins
    else if (tick_i && match_i)  flag_o <= 1'b1;
  end

  assert_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && match_i && !access_i) |=> flag_o);
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_i |=> !flag_o);
  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !access_i) |=> flag_o);
  assert_tick_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !tick_i) |=> !flag_o);
endmodule

// File: rtl/clk_alarm_match.sv
module clk_alarm_match
  import clk_alarm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [7:0] cur_sec_i,
  input  logic [7:0] cur_min_i,
  input  logic [7:0] cur_hour_i,
  input  logic [7:0] cur_day_i,
  input  logic [1:0] addr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       access_i,
  output logic [7:0] rd_data_o,
  output logic       alarm_o
);
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] clock_f;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alarm_f;
  logic                              match;

  assign clock_f = {cur_day_i, cur_hour_i, cur_min_i, cur_sec_i};

  alarm_regfile #(.NF(NUM_FIELDS), .BW(BYTE_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .alarm_q_o (alarm_f)
  );

  alarm_compare #(.NF(NUM_FIELDS), .BW(BYTE_W)) u_cmp (
    .clock_i (clock_f),
    .alarm_i (alarm_f),
    .match_o (match)
  );

  alarm_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .match_i  (match),
    .access_i (access_i),
    .flag_o   (alarm_o)
  );

  // R5: flag only rises after a tick
  assert_rise_needs_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(tick_i));
endmodule

// File: tb/clk_alarm_match_test.sv
`timescale 1ns/1ps
module clk_alarm_match_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] cur_sec_i = '0, cur_min_i = '0, cur_hour_i = '0, cur_day_i = '0;
  logic [1:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       access_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       alarm_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  clk_alarm_match uut (.*);

  typedef struct packed {
    logic [7:0] sec, mn, hr, day;
    logic       exp;
  } vec_t;

  // alarm programmed to 08:45:30, 24-hour, day 3
  localparam vec_t VECS [8] = '{
    '{8'h30, 8'h45, 8'h08, 8'h03, 1'b1},  // R5 exact match
    '{8'h31, 8'h45, 8'h08, 8'h03, 1'b0},  // R7 seconds off
    '{8'h30, 8'h46, 8'h08, 8'h03, 1'b0},  // R7 minutes off
    '{8'h30, 8'h45, 8'h09, 8'h03, 1'b0},  // R7 hours off
    '{8'h30, 8'h45, 8'h08, 8'h04, 1'b0},  // R7 day off
    '{8'hB0, 8'hC5, 8'h88, 8'hF3, 1'b1},  // R10 masked bits high
    '{8'h30, 8'h45, 8'h48, 8'h03, 1'b0},  // R4 12-hour bit
    '{8'h30, 8'h45, 8'h28, 8'h03, 1'b0}   // R4 bit 5
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; #1 d = rd_data_o;
  endtask

  task automatic pulse_access();
    @(negedge clk_i); access_i = 1'b1;
    @(negedge clk_i); access_i = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic set_clock(input logic [7:0] s, m, h, d);
    @(negedge clk_i); cur_sec_i = s; cur_min_i = m; cur_hour_i = h; cur_day_i = d;
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 flag", {7'd0, alarm_o}, 8'h00);
    rd(2'd0, d); chk("R1 sec", d, 8'h00);
    rd(2'd1, d); chk("R1 min", d, 8'h00);
    rd(2'd2, d); chk("R1 hour", d, 8'h52);
    rd(2'd3, d); chk("R1 day", d, 8'h01);

    // R3 masked writes
    wr(2'd3, 8'hFF); rd(2'd3, d); chk("R3 day mask", d, 8'h07);
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R3 sec mask", d, 8'h7F);

    // R2 program alarm
    wr(2'd0, 8'h30); wr(2'd1, 8'h45); wr(2'd2, 8'h08); wr(2'd3, 8'h03);
    rd(2'd0, d); chk("R2 sec", d, 8'h30);
    rd(2'd1, d); chk("R2 min", d, 8'h45);
    rd(2'd2, d); chk("R2 hour", d, 8'h08);
    rd(2'd3, d); chk("R2 day", d, 8'h03);

    // vector table
    foreach (VECS[i]) begin
      set_clock(VECS[i].sec, VECS[i].mn, VECS[i].hr, VECS[i].day);
      pulse_access();
      pulse_tick();
      chk($sformatf("R5/R7/R4/R10 vec%0d", i), {7'd0, alarm_o}, {7'd0, VECS[i].exp});
    end

    // R6: match present, no tick
    set_clock(8'h30, 8'h45, 8'h08, 8'h03);
    pulse_access();
    repeat (5) @(negedge clk_i);
    chk("R6 no tick", {7'd0, alarm_o}, 8'h00);

    // R8: sticky across a mismatching tick
    pulse_tick();
    chk("R5 set", {7'd0, alarm_o}, 8'h01);
    set_clock(8'h31, 8'h45, 8'h08, 8'h03);
    pulse_tick();
    repeat (3) @(negedge clk_i);
    chk("R8 sticky", {7'd0, alarm_o}, 8'h01);

    // R9: clear
    pulse_access();
    chk("R9 clear", {7'd0, alarm_o}, 8'h00);

    // R9: clear and matching tick together
    set_clock(8'h30, 8'h45, 8'h08, 8'h03);
    pulse_tick();
    chk("R9 reset up", {7'd0, alarm_o}, 8'h01);
    @(negedge clk_i); access_i = 1'b1; tick_i = 1'b1;
    @(negedge clk_i); access_i = 1'b0; tick_i = 1'b0;
    chk("R9 clear wins", {7'd0, alarm_o}, 8'h00);
    pulse_tick();
    chk("R9 rematch", {7'd0, alarm_o}, 8'h01);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule